// File: doc/BRIEF.md
# Subcarrier Frequency Lock Stream Receiver

This block takes a one-wire serial lock stream from an external video decoder. It recovers the subcarrier frequency word that the decoder measured for the incoming video, so that the encoder's subcarrier can follow line-length variation one line at a time. The data pin is sampled on the system clock. Every frame is a start marker followed by a fixed count of data bits. The low-order field of the frame carries the frequency word. The other bits are received and then dropped.

A completed word waits in a staging register. The word moves to the output only when the next line-start pulse arrives, so the phase accumulator downstream sees at most one change per video line. A one-cycle strobe marks each change. The receiver runs only while the two-bit mode input selects frequency-lock operation. Leaving that mode throws away any frame in progress and any word not yet delivered. The output keeps its last value.

Top module: `sfl_rx`

## Requirements
- R1: The receiver is active only while `mode` equals 2'b11. With any other value it starts no frame and raises no strobe.
- R2: A frame starts when `sfl_data` goes high after at least 4 consecutive low clocks seen while active. The first clock high is the first clock of a start-marker period lasting one bit period. Exactly 4 low clocks is enough.
- R3: Each of the 67 data bits after the marker lasts 2 clocks and is sampled on the second clock of its period. The value on the first clock has no effect.
- R4: Bit 0 is sent first. `fsc_word` is frame bits 0 to 21, with frame bit 0 as its LSB. Frame bits 22 to 66 have no effect on it.
- R5: A completed word is staged. On the first `line_start` high cycle after the frame completes, it appears on `fsc_word` in the next cycle, with `fsc_valid` high for that one cycle. At all other times `fsc_word` holds its value.
- R6: Each completed frame is delivered once. A `line_start` with no staged word raises no strobe and leaves `fsc_word` unchanged.
- R7: If a newer frame completes before delivery, it replaces the staged word. Only the newest word is delivered.
- R8: When `mode` leaves 2'b11, a partial frame is discarded and any undelivered staged word is dropped. `fsc_word` keeps its last value.
- R9: After reset, `fsc_word` is 0 and `fsc_valid` is 0.
- R10: A rising edge after fewer than 4 low clocks does not start a frame, and a high level held without a rising edge does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode; 2'b11 selects frequency-lock reception |
| sfl_data | input | 1 | Serial lock stream from the decoder |
| line_start | input | 1 | One-cycle pulse at each video line boundary |
| fsc_word | output | 22 | Subcarrier frequency word for the phase accumulator |
| fsc_valid | output | 1 | One-cycle strobe when `fsc_word` takes a new value |

## Verification
The assertions assume that `line_start` is a clean synchronous pulse and that `mode` changes only between clock edges. The frame-length check also assumes that the stream never holds the receiver busy for longer than one marker plus 67 bit periods. The bench drives every input on the falling edge and sends only whole or deliberately aborted frames, each built bit by bit from the stated timing. It puts deliberately wrong values on the first clock of each bit, which exercises the sampling point without breaking those assumptions.

// File: rtl/sfl_rx_pkg.sv
package sfl_rx_pkg;
   typedef enum logic {
      FRM_IDLE = 1'b0,
      FRM_BUSY = 1'b1
   } frm_state_e;
endpackage

// File: rtl/sfl_framer.sv
// Detects a frame start after an idle gap and produces per-bit sample strobes.
module sfl_framer
   import sfl_rx_pkg::*;
#(
   parameter int FRAME_BITS   = 67,
   parameter int CLKS_PER_BIT = 2,
   parameter int SAMPLE_AT    = 1,
   parameter int IDLE_MIN     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic busy_o,
   output logic sample_o,
   output logic last_o
);
   localparam int PH_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
   localparam int BC_W = $clog2(FRAME_BITS + 1);
   localparam int ID_W = $clog2(IDLE_MIN + 1);

   frm_state_e      state;
   logic [PH_W-1:0] ph;
   logic [BC_W-1:0] bcnt;
   logic [ID_W-1:0] idle_cnt;
   logic            start;

   assign start = (state == FRM_IDLE) && din && (idle_cnt == ID_W'(IDLE_MIN));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         state    <= FRM_IDLE;
         ph       <= '0;
         bcnt     <= '0;
         idle_cnt <= '0;
      end else if (state == FRM_IDLE) begin
         if (start) begin
            state    <= FRM_BUSY;
            ph       <= PH_W'(1);
            bcnt     <= '0;
            idle_cnt <= '0;
         end else if (din) begin
            idle_cnt <= '0;
         end else if (idle_cnt != ID_W'(IDLE_MIN)) begin
            idle_cnt <= idle_cnt + ID_W'(1);
         end
      end else begin
         if (ph == PH_W'(CLKS_PER_BIT - 1)) begin
            ph <= '0;
            if (bcnt == BC_W'(FRAME_BITS)) state <= FRM_IDLE;
            else                          bcnt  <= bcnt + BC_W'(1);
         end else begin
            ph <= ph + PH_W'(1);
         end
      end
   end

   assign busy_o   = (state == FRM_BUSY);
   assign sample_o = busy_o && (ph == PH_W'(SAMPLE_AT)) && (bcnt != '0);
   assign last_o   = sample_o && (bcnt == BC_W'(FRAME_BITS));
endmodule

// File: rtl/sfl_shifter.sv
// Assembles sampled bits and exposes the frequency field in frame-bit order.
module sfl_shifter #(
   parameter int FRAME_BITS = 67,
   parameter int FREQ_W     = 22,
   parameter int FREQ_LSB   = 0,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic              last,
   input  logic              din,
   output logic [FREQ_W-1:0] field_o,
   output logic              done_o
);
   logic [FRAME_BITS-1:0] sreg;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         always_ff @(posedge clk) begin
            if (!rst_n)      sreg <= '0;
            else if (sample) sreg <= {din, sreg[FRAME_BITS-1:1]};
         end
         for (genvar i = 0; i < FREQ_W; i++) begin : g_map
            assign field_o[i] = sreg[FREQ_LSB + i];
         end
      end else begin : g_msb_first
         always_ff @(posedge clk) begin
            if (!rst_n)      sreg <= '0;
            else if (sample) sreg <= {sreg[FRAME_BITS-2:0], din};
         end
         for (genvar i = 0; i < FREQ_W; i++) begin : g_map
            assign field_o[i] = sreg[FRAME_BITS - 1 - FREQ_LSB - i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) done_o <= 1'b0;
      else        done_o <= last;
   end
endmodule

// File: rtl/sfl_update.sv
// Stages a completed word and releases it at the next line boundary.
module sfl_update #(
   parameter int FREQ_W = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              done,
   input  logic [FREQ_W-1:0] field,
   input  logic              line_start,
   output logic [FREQ_W-1:0] word_o,
   output logic              valid_o
);
   logic [FREQ_W-1:0] stage;
   logic              pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage   <= '0;
         pend    <= 1'b0;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (!en) begin
            pend <= 1'b0;
         end else begin
            if (line_start && pend) begin
               word_o  <= stage;
               valid_o <= 1'b1;
               pend    <= 1'b0;
            end
            if (done) begin
               stage <= field;
               pend  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sfl_rx.sv
module sfl_rx #(
   parameter int               FRAME_BITS   = 67,
   parameter int               CLKS_PER_BIT = 2,
   parameter int               SAMPLE_AT    = 1,
   parameter int               IDLE_MIN     = 4,
   parameter int               FREQ_W       = 22,
   parameter int               FREQ_LSB     = 0,
   parameter bit               LSB_FIRST    = 1'b1,
   parameter int               MODE_W       = 2,
   parameter logic [MODE_W-1:0] MODE_LOCK   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              sfl_data,
   input  logic              line_start,
   output logic [FREQ_W-1:0] fsc_word,
   output logic              fsc_valid
);
   generate
      if (CLKS_PER_BIT < 2) begin : g_bad_clks
         $error("sfl_rx: CLKS_PER_BIT must be at least 2");
      end
      if (SAMPLE_AT < 1 || SAMPLE_AT >= CLKS_PER_BIT) begin : g_bad_sample
         $error("sfl_rx: SAMPLE_AT must lie in 1..CLKS_PER_BIT-1");
      end
      if (FREQ_LSB + FREQ_W > FRAME_BITS) begin : g_bad_field
         $error("sfl_rx: frequency field exceeds frame");
      end
      if (IDLE_MIN < 1 || FRAME_BITS < 2) begin : g_bad_misc
         $error("sfl_rx: IDLE_MIN and FRAME_BITS too small");
      end
   endgenerate

   logic              en;
   logic              frm_busy;
   logic              smp;
   logic              smp_last;
   logic              frm_done;
   logic [FREQ_W-1:0] field;

   assign en = (mode == MODE_LOCK);

   sfl_framer #(
      .FRAME_BITS  (FRAME_BITS),
      .CLKS_PER_BIT(CLKS_PER_BIT),
      .SAMPLE_AT   (SAMPLE_AT),
      .IDLE_MIN    (IDLE_MIN)
   ) u_frm (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .din     (sfl_data),
      .busy_o  (frm_busy),
      .sample_o(smp),
      .last_o  (smp_last)
   );

   sfl_shifter #(
      .FRAME_BITS(FRAME_BITS),
      .FREQ_W    (FREQ_W),
      .FREQ_LSB  (FREQ_LSB),
      .LSB_FIRST (LSB_FIRST)
   ) u_shf (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (smp),
      .last   (smp_last),
      .din    (sfl_data),
      .field_o(field),
      .done_o (frm_done)
   );

   sfl_update #(
      .FREQ_W(FREQ_W)
   ) u_upd (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .done      (frm_done),
      .field     (field),
      .line_start(line_start),
      .word_o    (fsc_word),
      .valid_o   (fsc_valid)
   );
endmodule

// File: rtl/sfl_rx_chk.sv
module sfl_rx_chk #(
   parameter int               FRAME_BITS   = 67,
   parameter int               CLKS_PER_BIT = 2,
   parameter int               FREQ_W       = 22,
   parameter int               MODE_W       = 2,
   parameter logic [MODE_W-1:0] MODE_LOCK   = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode,
   input logic              line_start,
   input logic              busy,
   input logic [FREQ_W-1:0] fsc_word,
   input logic              fsc_valid
);
   localparam int LEN   = (FRAME_BITS + 1) * CLKS_PER_BIT;
   localparam int LEN_W = $clog2(LEN + 2);

   logic [LEN_W-1:0] busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + LEN_W'(1);
      else           busy_len <= '0;
   end

   // R5: a strobe follows a line-start cycle
   a_r5_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
      fsc_valid |-> $past(line_start));

   // R5: the word changes only together with the strobe
   a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fsc_word) |-> fsc_valid);

   // R1: no strobe unless the lock mode was selected
   a_r1_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      fsc_valid |-> ($past(mode) == MODE_LOCK));

   // R8: leaving the mode ends any frame in progress
   a_r8_abort_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_LOCK) |=> !busy);

   // R3: a frame never outlasts marker plus all bit periods
   a_r3_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < LEN_W'(LEN - 1)));
endmodule

bind sfl_rx sfl_rx_chk #(
   .FRAME_BITS  (FRAME_BITS),
   .CLKS_PER_BIT(CLKS_PER_BIT),
   .FREQ_W      (FREQ_W),
   .MODE_W      (MODE_W),
   .MODE_LOCK   (MODE_LOCK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .line_start(line_start),
   .busy      (frm_busy),
   .fsc_word  (fsc_word),
   .fsc_valid (fsc_valid)
);

// File: tb/sfl_rx_tb.sv
module sfl_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NB         = 67;
   localparam int FW         = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode = 2'b11;
   logic          sfl_data = 1'b0;
   logic          line_start = 1'b0;
   logic [FW-1:0] fsc_word;
   logic          fsc_valid;

   int            n_chk = 0;
   int            n_fail = 0;
   logic [FW-1:0] exp_q[$];
   logic [FW-1:0] exp_stage = '0;
   logic          exp_pend = 1'b0;
   logic [FW-1:0] last_word = '0;

   sfl_rx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .sfl_data  (sfl_data),
      .line_start(line_start),
      .fsc_word  (fsc_word),
      .fsc_valid (fsc_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_mode(input logic [1:0] m);
      mode = m;
      if (m != 2'b11) exp_pend = 1'b0;   // R8 model: staged word dropped
   endtask

   // Sends marker plus NB bits; glitch drives the inverse on each first clock (R3)
   task automatic send_frame(input logic [NB-1:0] f, input int gap, input bit glitch, input int abort_at);
      sfl_data = 1'b0;
      repeat (gap) tick();
      sfl_data = 1'b1;
      repeat (2) tick();
      for (int k = 0; k < NB; k++) begin
         if (k == abort_at) set_mode(2'b00);
         sfl_data = glitch ? ~f[k] : f[k];
         tick();
         sfl_data = f[k];
         tick();
      end
      sfl_data = 1'b0;
      repeat (2) tick();
      if (abort_at < 0 && mode == 2'b11) begin
         exp_stage = f[FW-1:0];
         exp_pend  = 1'b1;
      end
   endtask

   function automatic logic [NB-1:0] mk_frame(input logic [FW-1:0] w);
      logic [95:0] r;
      r = {$urandom(), $urandom(), $urandom()};
      return {r[NB-1:FW], w};
   endfunction

   // Line pulse where the model expects a delivery (driver side of scoreboard)
   task automatic line_pulse();
      if (exp_pend && mode == 2'b11) begin
         exp_q.push_back(exp_stage);
         last_word = exp_stage;
         exp_pend  = 1'b0;
      end
      line_start = 1'b1;
      tick();
      line_start = 1'b0;
      repeat (2) tick();
   endtask

   // Line pulse where nothing may be delivered
   task automatic expect_none(input string req);
      line_start = 1'b1;
      tick();
      line_start = 1'b0;
      chk(fsc_valid == 1'b0, req, 32'(fsc_valid), 32'd0);
      chk(fsc_word == last_word, req, 32'(fsc_word), 32'(last_word));
      tick();
   endtask

   // Monitor: pops expected words as strobes appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && fsc_valid) begin
            if (exp_q.size() == 0) begin
               n_chk++;
               n_fail++;
               $display("FAIL R6 actual=unexpected strobe word %h expected=no strobe", fsc_word);
            end else begin
               logic [FW-1:0] e;
               e = exp_q.pop_front();
               chk(fsc_word == e, "R4/R5 delivered word", 32'(fsc_word), 32'(e));
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) tick();
      // R9: reset state
      chk(fsc_word == '0, "R9 word after reset", 32'(fsc_word), 32'd0);
      chk(fsc_valid == 1'b0, "R9 strobe after reset", 32'(fsc_valid), 32'd0);
      rst_n = 1'b1;
      tick();

      // R4, R5: basic frame, delivered at line start
      send_frame(mk_frame(22'h2A5C3F), 6, 1'b0, -1);
      repeat (10) tick();
      line_pulse();
      // R6: a second line start delivers nothing
      expect_none("R6 no repeat delivery");

      // R3: inverted value on first clock of every bit
      send_frame(mk_frame(22'h15A3C6), 6, 1'b1, -1);
      line_pulse();

      // R7: two frames before a line start; newest wins
      send_frame(mk_frame(22'h000001), 6, 1'b0, -1);
      send_frame(mk_frame(22'h3FFFFE), 5, 1'b1, -1);
      line_pulse();

      // R1: other mode values ignore the stream
      set_mode(2'b01);
      send_frame(mk_frame(22'h123456), 6, 1'b0, -1);
      set_mode(2'b11);
      tick();
      expect_none("R1 mode 01 ignored");
      set_mode(2'b10);
      send_frame(mk_frame(22'h0F0F0F), 6, 1'b0, -1);
      set_mode(2'b11);
      tick();
      expect_none("R1 mode 10 ignored");

      // R8: abort mid-frame, then a clean frame
      send_frame(mk_frame(22'h3A3A3A), 6, 1'b0, 30);
      set_mode(2'b11);
      tick();
      expect_none("R8 partial frame discarded");
      send_frame(mk_frame(22'h0C0DE5), 6, 1'b0, -1);
      line_pulse();

      // R8: staged word dropped when mode is left
      send_frame(mk_frame(22'h111111), 6, 1'b0, -1);
      set_mode(2'b00);
      repeat (2) tick();
      set_mode(2'b11);
      tick();
      expect_none("R8 staged word dropped");

      // R10: short gaps and a held high level start nothing
      set_mode(2'b00);
      sfl_data = 1'b1;
      repeat (3) tick();
      set_mode(2'b11);
      repeat (3) tick();
      sfl_data = 1'b0;
      repeat (3) tick();
      sfl_data = 1'b1;
      repeat (10) tick();
      sfl_data = 1'b0;
      repeat (2) tick();
      sfl_data = 1'b1;
      repeat (200) tick();
      expect_none("R10 no start without idle gap");

      // R2: exactly the minimum idle gap from a high level
      send_frame(mk_frame(22'h2BEEF1), 4, 1'b0, -1);
      line_pulse();

      repeat (5) tick();
      chk(exp_q.size() == 0, "R5 all expected words delivered", 32'(exp_q.size()), 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule